// File: doc/BRIEF.md
# Zero-Operand Stack Processor Core

This core runs a byte-coded program in which arithmetic instructions name no operands. Values live on a small on-chip last-in-first-out store. An arithmetic instruction takes the two values at the top, combines them, and leaves one result on top. Two transfer instructions move data between that store and memory. One copies a memory byte onto the stack. The other removes the top value and writes it to memory. Each transfer instruction carries a 16-bit absolute address.

All traffic goes through one 8-bit memory port, and every access lasts exactly two clock cycles. This gives fixed instruction costs:

- An opcode fetch takes 2 cycles.
- A transfer instruction takes 8 cycles: opcode, two address bytes and the data access.
- An arithmetic instruction takes 3 cycles: opcode fetch plus one execute cycle.

The core stops when it meets a halt opcode or any opcode it does not know. It also stops on a stack fault, and it then raises a sticky overflow or underflow flag. A free-running cycle count and the current stack depth are brought out so that a program's cost and effect can be observed.

Top module: `sm_stack_core`

## Requirements
- R1: After reset the program counter is 0x0000, the stack is empty, both fault flags and `halted` are low, and the cycle count is 0. The first bus cycle reads address 0x0000.
- R2: Every instruction begins with a one-byte opcode at the program counter. The opcodes are 0x10 (copy memory to stack) and 0x11 (stack to memory), each followed by a two-byte absolute address sent low byte first, and 0x20 (add), 0x21 (multiply) and 0xFF (halt).
- R3: Each memory access holds `memRd` or `memWr` and a stable `memAddr` for two consecutive cycles. Read data is taken in the second cycle. Read and write are never high together.
- R4: Opcode 0x10 reads the byte at its address and places it on top of the stack. Depth rises by one, and the instruction takes 8 cycles.
- R5: Opcode 0x11 writes the top-of-stack value to its address and removes it from the stack. Depth falls by one, and the instruction takes 8 cycles.
- R6: Opcode 0x20 removes the two top values and pushes their sum modulo 256. Depth falls by one, and the instruction takes 3 cycles with no bus access in the third.
- R7: Opcode 0x21 removes the two top values and pushes the low 8 bits of their product, in 3 cycles.
- R8: Opcode 0xFF, or any unassigned opcode, halts the core after its 2-cycle fetch. A halted core makes no further memory access. The cycle count, which counts every cycle since reset up to and including the halting fetch, then stays frozen.
- R9: Opcode 0x10 fetched while the stack holds 8 entries sets a sticky `overflow` flag and halts. The stack is left unchanged.
- R10: Opcode 0x11 on an empty stack, or 0x20/0x21 with fewer than two entries, sets a sticky `underflow` flag and halts without touching memory.
- R11: The sequence push a, push c, multiply, push b, add, push a, add, pop a stores a+b+a*c in 49 cycles. With a trailing halt, the count reads 51.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 16 | Memory address, either program counter or operand address |
| memRd | output | 1 | Read access active |
| memWr | output | 1 | Write access active |
| memWdata | output | 8 | Write data (top of stack) |
| memRdata | input | 8 | Read data from memory |
| halted | output | 1 | Core has stopped |
| overflow | output | 1 | Sticky stack overflow flag |
| underflow | output | 1 | Sticky stack underflow flag |
| depth | output | 4 | Number of stack entries held |
| cycleCount | output | 32 | Cycles executed since reset |

## Verification
The bus is combinational from registered state. The access expected in cycle k is therefore visible between the k-th and (k+1)-th rising edges after reset is released, and the first opcode read is visible before the first edge. A behavioural interpreter in the bench turns each program into a per-cycle list of expected accesses: two cycles per byte, one idle cycle per arithmetic execute. The bench compares the port against that list at each falling edge. Once the list is used up, the core must read as halted on that very falling edge, with the count equal to the list length. Depth, flags and memory contents are then compared with the interpreter's final state, and the count is checked again one cycle later to confirm it is frozen.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam logic [7:0] OP_PUSH = 8'h10;
  localparam logic [7:0] OP_POP  = 8'h11;
  localparam logic [7:0] OP_ADD  = 8'h20;
  localparam logic [7:0] OP_MUL  = 8'h21;
  localparam logic [7:0] OP_HALT = 8'hFF;

  typedef enum logic [2:0] {
    ST_OPC, ST_ALO, ST_AHI, ST_XFER, ST_EXEC, ST_STOP
  } state_t;

  typedef struct packed {
    logic pcInc;    // advance program counter past a fetched byte
    logic addrLo;   // capture low address byte
    logic addrHi;   // capture high address byte
    logic useAddr;  // drive operand address instead of PC
    logic pushRd;   // push read data onto stack
    logic popTop;   // drop top of stack
    logic aluGo;    // combine two top entries
    logic aluMul;   // select product instead of sum
  } strobes_t;
endpackage

// File: rtl/sm_control.sv
module sm_control
  import sm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 32,
  localparam int DEP_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DEP_W-1:0]  depth,
  output strobes_t          stb,
  output logic              memRd,
  output logic              memWr,
  output logic              halted,
  output logic              overflow,
  output logic              underflow,
  output logic [CNT_W-1:0]  cycleCount
);
  state_t state, stateNext;
  logic phase;
  logic access;
  logic [DATA_W-1:0] opc;
  logic setOvf, setUdf;

  assign access = (state == ST_OPC) || (state == ST_ALO) ||
                  (state == ST_AHI) || (state == ST_XFER);
  assign halted = (state == ST_STOP);

  always_comb begin
    stb       = '0;
    memRd     = 1'b0;
    memWr     = 1'b0;
    setOvf    = 1'b0;
    setUdf    = 1'b0;
    stateNext = state;
    case (state)
      ST_OPC: begin
        memRd = 1'b1;
        if (phase) begin
          stb.pcInc = 1'b1;
          case (memRdata)
            OP_PUSH:
              if (depth == DEP_W'(DEPTH)) begin
                setOvf    = 1'b1;
                stateNext = ST_STOP;
              end else stateNext = ST_ALO;
            OP_POP:
              if (depth == '0) begin
                setUdf    = 1'b1;
                stateNext = ST_STOP;
              end else stateNext = ST_ALO;
            OP_ADD, OP_MUL:
              if (depth < DEP_W'(2)) begin
                setUdf    = 1'b1;
                stateNext = ST_STOP;
              end else stateNext = ST_EXEC;
            default: stateNext = ST_STOP;
          endcase
        end
      end
      ST_ALO: begin
        memRd = 1'b1;
        if (phase) begin
          stb.pcInc  = 1'b1;
          stb.addrLo = 1'b1;
          stateNext  = ST_AHI;
        end
      end
      ST_AHI: begin
        memRd = 1'b1;
        if (phase) begin
          stb.pcInc  = 1'b1;
          stb.addrHi = 1'b1;
          stateNext  = ST_XFER;
        end
      end
      ST_XFER: begin
        stb.useAddr = 1'b1;
        if (opc == OP_PUSH) memRd = 1'b1;
        else                memWr = 1'b1;
        if (phase) begin
          if (opc == OP_PUSH) stb.pushRd = 1'b1;
          else                stb.popTop = 1'b1;
          stateNext = ST_OPC;
        end
      end
      ST_EXEC: begin
        stb.aluGo  = 1'b1;
        stb.aluMul = (opc == OP_MUL);
        stateNext  = ST_OPC;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_OPC;
      phase      <= 1'b0;
      opc        <= '0;
      overflow   <= 1'b0;
      underflow  <= 1'b0;
      cycleCount <= '0;
    end else begin
      state     <= stateNext;
      phase     <= access && !phase;
      if (state == ST_OPC && phase) opc <= memRdata;
      overflow  <= overflow | setOvf;
      underflow <= underflow | setUdf;
      if (state != ST_STOP) cycleCount <= cycleCount + CNT_W'(1);
    end
  end

  p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  p_wr_two_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWr) |=> memWr);
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memRd && !memWr));
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(cycleCount)));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushRd |-> (depth < DEP_W'(DEPTH)));
  p_udf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);
  p_alu_two_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.aluGo |-> (depth >= DEP_W'(2)));
endmodule

// File: rtl/sm_datapath.sv
module sm_datapath
  import sm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int DEP_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DEP_W-1:0]  depth
);
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] stk [DEPTH];
  logic [PTR_W-1:0]  topIdx, secIdx, pushIdx;
  logic [DATA_W-1:0] sum;
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0] aluRes;
  logic              wrEn;
  logic [PTR_W-1:0]  wrIdx;
  logic [DATA_W-1:0] wrData;

  assign topIdx  = PTR_W'(depth - DEP_W'(1));
  assign secIdx  = PTR_W'(depth - DEP_W'(2));
  assign pushIdx = PTR_W'(depth);

  assign sum    = stk[secIdx] + stk[topIdx];
  assign prod   = {{DATA_W{1'b0}}, stk[secIdx]} * {{DATA_W{1'b0}}, stk[topIdx]};
  assign aluRes = stb.aluMul ? prod[DATA_W-1:0] : sum;

  assign wrEn   = stb.pushRd | stb.aluGo;
  assign wrIdx  = stb.pushRd ? pushIdx : secIdx;
  assign wrData = stb.pushRd ? memRdata : aluRes;

  assign memAddr  = stb.useAddr ? addrReg : pc;
  assign memWdata = stk[topIdx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] slot;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              slot <= '0;
      else if (wrEn && wrIdx == PTR_W'(g))    slot <= wrData;
    end
    assign stk[g] = slot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      addrReg <= '0;
      depth   <= '0;
    end else begin
      if (stb.pcInc)  pc <= pc + ADDR_W'(1);
      if (stb.addrLo) addrReg[DATA_W-1:0]      <= memRdata;
      if (stb.addrHi) addrReg[ADDR_W-1:DATA_W] <= memRdata;
      if (stb.pushRd)                    depth <= depth + DEP_W'(1);
      else if (stb.popTop || stb.aluGo)  depth <= depth - DEP_W'(1);
    end
  end

  p_push_grow_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushRd |=> (depth == $past(depth) + DEP_W'(1)));
  p_pop_shrink_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.popTop |=> (depth == $past(depth) - DEP_W'(1)));
  p_alu_shrink_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.aluGo |=> (depth == $past(depth) - DEP_W'(1)));
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEP_W'(DEPTH));
endmodule

// File: rtl/sm_stack_core.sv
module sm_stack_core
  import sm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  output logic [2*DATA_W-1:0]          memAddr,
  output logic                         memRd,
  output logic                         memWr,
  output logic [DATA_W-1:0]            memWdata,
  input  logic [DATA_W-1:0]            memRdata,
  output logic                         halted,
  output logic                         overflow,
  output logic                         underflow,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic [CNT_W-1:0]             cycleCount
);
  strobes_t stb;

  sm_control #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_control (
    .clk(clk), .rstN(rstN), .memRdata(memRdata), .depth(depth), .stb(stb),
    .memRd(memRd), .memWr(memWr), .halted(halted), .overflow(overflow),
    .underflow(underflow), .cycleCount(cycleCount)
  );

  sm_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .depth(depth)
  );
endmodule

// File: tb/test_sm_stack_core.sv
module test_sm_stack_core;
  localparam int DEPTH = 8;
  localparam int MSZ   = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic [15:0] memAddr;
  logic        memRd, memWr;
  logic [7:0]  memWdata, memRdata;
  logic        halted, overflow, underflow;
  logic [3:0]  depth;
  logic [31:0] cycleCount;

  logic [7:0] img    [MSZ];
  logic [7:0] mem    [MSZ];
  logic [7:0] refMem [MSZ];

  int checks = 0;
  int fails  = 0;
  int wp;

  int  trRd[$], trWr[$], trAddr[$];
  int  expCycles, expDepth;
  bit  expOvf, expUdf;

  sm_stack_core i_sm_stack_core (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata), .halted(halted),
    .overflow(overflow), .underflow(underflow), .depth(depth),
    .cycleCount(cycleCount)
  );

  assign memRdata = mem[memAddr[9:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MSZ; i++) mem[i] = img[i];
    end else if (memWr) begin
      mem[memAddr[9:0]] = memWdata;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearImg();
    for (int i = 0; i < MSZ; i++) img[i] = 8'h00;
    wp = 0;
  endtask

  task automatic putOp(input int op);
    img[wp] = 8'(op);
    wp++;
  endtask

  task automatic putXfer(input int op, input int addr);
    img[wp] = 8'(op); img[wp+1] = 8'(addr); img[wp+2] = 8'(addr >> 8);
    wp += 3;
  endtask

  task automatic emit(input int rd, input int wr, input int addr);
    trRd.push_back(rd); trWr.push_back(wr); trAddr.push_back(addr);
  endtask

  // behavioural interpreter producing the expected per-cycle bus activity
  task automatic buildModel();
    int stk[$];
    int pc;
    int guard;
    bit run;
    trRd.delete(); trWr.delete(); trAddr.delete();
    expOvf = 0; expUdf = 0; pc = 0; guard = 0; run = 1;
    for (int i = 0; i < MSZ; i++) refMem[i] = img[i];
    while (run && guard < 500) begin
      int op;
      guard++;
      emit(1, 0, pc); emit(1, 0, pc);
      op = int'(refMem[pc % MSZ]); pc++;
      if (op == 'h10 || op == 'h11) begin
        if (op == 'h10 && stk.size() == DEPTH) begin
          expOvf = 1; run = 0;
        end else if (op == 'h11 && stk.size() == 0) begin
          expUdf = 1; run = 0;
        end else begin
          int a;
          emit(1, 0, pc); emit(1, 0, pc); a = int'(refMem[pc % MSZ]); pc++;
          emit(1, 0, pc); emit(1, 0, pc); a = a | (int'(refMem[pc % MSZ]) << 8); pc++;
          if (op == 'h10) begin
            emit(1, 0, a); emit(1, 0, a);
            stk.push_back(int'(refMem[a % MSZ]));
          end else begin
            emit(0, 1, a); emit(0, 1, a);
            refMem[a % MSZ] = 8'(stk.pop_back());
          end
        end
      end else if (op == 'h20 || op == 'h21) begin
        if (stk.size() < 2) begin
          expUdf = 1; run = 0;
        end else begin
          int x, y;
          emit(0, 0, 0);
          y = stk.pop_back(); x = stk.pop_back();
          stk.push_back(op == 'h20 ? ((x + y) & 255) : ((x * y) & 255));
        end
      end else begin
        run = 0;
      end
    end
    expCycles = trRd.size();
    expDepth  = stk.size();
  endtask

  task automatic runProg(input string nm);
    int firstBad;
    int badAct, badExp;
    int memBad;
    rstN = 1'b0;
    buildModel();
    @(negedge clk); @(negedge clk);
    check(depth == 0 && cycleCount == 0 && !halted && !overflow && !underflow
          && memAddr == 16'h0000 && memRd && !memWr,
          {nm, " R1 reset state"}, {depth, cycleCount[7:0]}, 0);
    rstN = 1'b1;
    firstBad = -1; badAct = 0; badExp = 0;
    for (int i = 0; i < expCycles; i++) begin
      bit ok;
      ok = (int'(memRd) == trRd[i]) && (int'(memWr) == trWr[i]) &&
           ((trRd[i] == 0 && trWr[i] == 0) || int'(memAddr) == trAddr[i]);
      if (!ok && firstBad < 0) begin
        firstBad = i;
        badAct = (int'(memRd) << 20) | (int'(memWr) << 16) | int'(memAddr);
        badExp = (trRd[i] << 20) | (trWr[i] << 16) | trAddr[i];
      end
      @(negedge clk);
    end
    check(firstBad < 0, {nm, " R2/R3 per-cycle bus trace"}, badAct, badExp);
    check(halted && !memRd && !memWr, {nm, " R8 halted and quiet"},
          {halted, memRd, memWr}, 3'b100);
    check(cycleCount == 32'(expCycles), {nm, " R8 cycle count at halt"},
          cycleCount, expCycles);
    check(depth == 4'(expDepth), {nm, " R4/R5/R6 final depth"}, depth, expDepth);
    check(overflow == expOvf, {nm, " R9 overflow flag"}, overflow, expOvf);
    check(underflow == expUdf, {nm, " R10 underflow flag"}, underflow, expUdf);
    memBad = 0;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== refMem[i]) memBad++;
    check(memBad == 0, {nm, " R5/R6/R7 memory contents"}, memBad, 0);
    @(negedge clk);
    check(cycleCount == 32'(expCycles) && halted, {nm, " R8 count frozen"},
          cycleCount, expCycles);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=halt", cycleCount);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // P1: a = a + b + a*c, a@0x105=3, b@0x106=5, c@0x107=7 (R11, R4..R7)
    clearImg();
    putXfer('h10, 'h105); putXfer('h10, 'h107); putOp('h21);
    putXfer('h10, 'h106); putOp('h20); putXfer('h10, 'h105); putOp('h20);
    putXfer('h11, 'h105); putOp('hFF);
    img['h105] = 8'd3; img['h106] = 8'd5; img['h107] = 8'd7;
    runProg("expr");
    check(cycleCount == 32'd51, "R11 example sequence cost", cycleCount, 51);
    check(mem['h105] == 8'd29, "R11 example result", mem['h105], 29);

    // P2: wrap-around add and truncated multiply, high address byte 0x02 (R6, R7)
    clearImg();
    putXfer('h10, 'h210); putXfer('h10, 'h211); putOp('h20); putXfer('h11, 'h220);
    putXfer('h10, 'h212); putXfer('h10, 'h213); putOp('h21); putXfer('h11, 'h221);
    putOp('hFF);
    img['h210] = 8'd200; img['h211] = 8'd100; img['h212] = 8'h10; img['h213] = 8'h11;
    runProg("wrap");
    check(mem['h220] == 8'd44, "R6 sum modulo 256", mem['h220], 44);
    check(mem['h221] == 8'h10, "R7 low product byte", mem['h221], 'h10);

    // P3: nine pushes overflow an 8-deep stack (R9)
    clearImg();
    for (int k = 0; k < 9; k++) putXfer('h10, 'h300 + k);
    putOp('hFF);
    for (int k = 0; k < 9; k++) img['h300 + k] = 8'(k + 1);
    runProg("overflow");

    // P4: store from empty stack (R10)
    clearImg();
    putXfer('h11, 'h310); putOp('hFF);
    img['h310] = 8'h5A;
    runProg("pop-empty");
    check(mem['h310] == 8'h5A, "R10 memory untouched on underflow", mem['h310], 'h5A);

    // P5: add with a single entry (R10)
    clearImg();
    putXfer('h10, 'h320); putOp('h20); putOp('hFF);
    img['h320] = 8'h22;
    runProg("add-one");

    // P6: unassigned opcode stops the core (R8)
    clearImg();
    putXfer('h10, 'h330); putOp('h42); putXfer('h10, 'h330); putOp('hFF);
    img['h330] = 8'h07;
    runProg("bad-opcode");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule